// File: doc/BRIEF.md
# Per-Channel Output Source Selector

This block sits between the connection tables and the serializers of a time-slot switch. Each output time slot is presented as a stream and channel number, together with the high and low connection words for that slot. From these the block decides which byte goes out in that slot.

The byte is either a switched byte or a fixed message byte. A switched byte is read from the data memory at the source slot named by the connection words. A message byte is the low connection word itself. The block also decides whether the output driver is on for that slot.

A chip-wide message switch makes every slot behave as a driven message slot, whatever the stored control bits say. An external drive-enable pin can silence every slot. The chosen byte, the drive flag and the slot tag leave the block through a register stage, one cycle after the slot is presented. Serialization is done downstream.

Top module: `slot_src_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_vld`, `out_oe` and `out_data` are all zero.
- R2: When `msg_all` is 0 and bit 2 of `cmh_word` is 0, `out_data` equals the data memory byte at the source address one cycle after the slot is presented.
- R3: `dm_raddr` is `{cmh_word[5:3], cml_word[4:0]}`, i.e. source stream × 32 + source channel. `dm_rd_en` is high only for a presented slot that is in switched mode.
- R4: When `msg_all` is 0 and bit 2 of `cmh_word` is 1, `out_data` equals all 8 bits of `cml_word` one cycle later.
- R5: When `ode_pin` is 1 and `msg_all` is 0, `out_oe` one cycle after a presented slot equals bit 0 of `cmh_word`.
- R6: When `msg_all` is 1, every presented slot outputs `cml_word` with `out_oe` equal to `ode_pin`, whatever bits 2 and 0 of `cmh_word` hold.
- R7: When `ode_pin` is 0, `out_oe` is 0 one cycle later, whatever the connection words and `msg_all` hold.
- R8: One cycle after `slot_vld` is high, `out_vld` is 1 and `out_stream` and `out_chan` carry that slot's stream and channel.
- R9: One cycle after `slot_vld` is low, `out_vld` and `out_oe` are 0, and `out_data`, `out_stream` and `out_chan` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 1 | An output slot is presented this cycle |
| slot_stream | input | 3 | Output stream of the presented slot |
| slot_chan | input | 5 | Output channel of the presented slot |
| cmh_word | input | 8 | High connection word: [0] drive, [2] message, [5:3] source stream |
| cml_word | input | 8 | Low connection word: message byte, [4:0] source channel |
| msg_all | input | 1 | Global message mode |
| ode_pin | input | 1 | External drive enable, low silences all slots |
| dm_raddr | output | 8 | Data memory read address |
| dm_rd_en | output | 1 | Data memory read strobe |
| dm_rdata | input | 8 | Data memory read data, same-cycle |
| out_vld | output | 1 | Registered slot valid |
| out_stream | output | 3 | Registered slot stream tag |
| out_chan | output | 5 | Registered slot channel tag |
| out_data | output | 8 | Registered output byte |
| out_oe | output | 1 | Registered driver enable |

## Verification
Several checks run on every cycle against one-cycle-earlier inputs:
- the source of the byte in both modes;
- the silencing by the drive pin;
- the hold behaviour of idle cycles;
- the read strobe gating;
- the tag pass-through.

Only the bench scenarios can show the following:
- the source address is assembled from the right fields;
- the global mode overrides cleared stored bits in both positions;
- the reset values.

The bench covers long runs where modes, the pin and idle gaps change from slot to slot.

// File: rtl/slot_src_pkg.sv
package slot_src_pkg;
  // effective per-slot control after global override
  typedef struct packed {
    logic msg;
    logic drv;
  } slot_ctl_t;
endpackage

// File: rtl/slot_ctl_decode.sv
module slot_ctl_decode
  import slot_src_pkg::*;
#(
  parameter int CMH_W   = 8,
  parameter int MSG_BIT = 2,
  parameter int OE_BIT  = 0
) (
  input  logic [CMH_W-1:0] cmh,
  input  logic             msg_all,
  output slot_ctl_t        ctl
);
  always_comb begin
    ctl.msg = msg_all | cmh[MSG_BIT];
    ctl.drv = msg_all | cmh[OE_BIT];
  end
endmodule

// File: rtl/slot_src_addr.sv
module slot_src_addr #(
  parameter int CMH_W    = 8,
  parameter int CML_W    = 8,
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5,
  parameter int SAB_LSB  = 3,
  localparam int ADDR_W  = STREAM_W + CHAN_W
) (
  input  logic [CMH_W-1:0]  cmh,
  input  logic [CML_W-1:0]  cml,
  output logic [ADDR_W-1:0] addr
);
  always_comb addr = {cmh[SAB_LSB +: STREAM_W], cml[CHAN_W-1:0]};
endmodule

// File: rtl/slot_out_stage.sv
module slot_out_stage
  import slot_src_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_vld,
  input  logic [STREAM_W-1:0] slot_stream,
  input  logic [CHAN_W-1:0]   slot_chan,
  input  slot_ctl_t           ctl,
  input  logic                ode_pin,
  input  logic [DATA_W-1:0]   msg_byte,
  input  logic [DATA_W-1:0]   sw_byte,
  output logic                out_vld,
  output logic [STREAM_W-1:0] out_stream,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_oe
);
  logic [DATA_W-1:0] pick;
  always_comb pick = ctl.msg ? msg_byte : sw_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld    <= 1'b0;
      out_oe     <= 1'b0;
      out_data   <= '0;
      out_stream <= '0;
      out_chan   <= '0;
    end else begin
      out_vld <= slot_vld;
      out_oe  <= slot_vld & ode_pin & ctl.drv;
      if (slot_vld) begin
        out_data   <= pick;
        out_stream <= slot_stream;
        out_chan   <= slot_chan;
      end
    end
  end

  // R4 R6
  msg_path_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_vld && ctl.msg) |=> out_data == $past(msg_byte));
  // R2
  switch_path_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_vld && !ctl.msg) |=> out_data == $past(sw_byte));
  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ode_pin |=> !out_oe);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_vld |=> (!out_vld && !out_oe && $stable(out_data)));
  // R8
  tag_chk: assert property (@(posedge clk) disable iff (rst)
    slot_vld |=> (out_vld && out_stream == $past(slot_stream)
                  && out_chan == $past(slot_chan)));
endmodule

// File: rtl/slot_src_sel.sv
module slot_src_sel
  import slot_src_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STREAM_W = 3,
  parameter int CHAN_W   = 5,
  parameter int CMH_W    = 8,
  parameter int MSG_BIT  = 2,
  parameter int OE_BIT   = 0,
  parameter int SAB_LSB  = 3,
  localparam int ADDR_W  = STREAM_W + CHAN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_vld,
  input  logic [STREAM_W-1:0] slot_stream,
  input  logic [CHAN_W-1:0]   slot_chan,
  input  logic [CMH_W-1:0]    cmh_word,
  input  logic [DATA_W-1:0]   cml_word,
  input  logic                msg_all,
  input  logic                ode_pin,
  output logic [ADDR_W-1:0]   dm_raddr,
  output logic                dm_rd_en,
  input  logic [DATA_W-1:0]   dm_rdata,
  output logic                out_vld,
  output logic [STREAM_W-1:0] out_stream,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_oe
);
  slot_ctl_t ctl;

  slot_ctl_decode #(.CMH_W(CMH_W), .MSG_BIT(MSG_BIT), .OE_BIT(OE_BIT)) u_dec (
    .cmh(cmh_word), .msg_all(msg_all), .ctl(ctl));

  slot_src_addr #(.CMH_W(CMH_W), .CML_W(DATA_W), .STREAM_W(STREAM_W),
                  .CHAN_W(CHAN_W), .SAB_LSB(SAB_LSB)) u_addr (
    .cmh(cmh_word), .cml(cml_word), .addr(dm_raddr));

  always_comb dm_rd_en = slot_vld & ~ctl.msg;

  slot_out_stage #(.DATA_W(DATA_W), .STREAM_W(STREAM_W), .CHAN_W(CHAN_W)) u_out (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_stream(slot_stream),
    .slot_chan(slot_chan), .ctl(ctl), .ode_pin(ode_pin), .msg_byte(cml_word),
    .sw_byte(dm_rdata), .out_vld(out_vld), .out_stream(out_stream),
    .out_chan(out_chan), .out_data(out_data), .out_oe(out_oe));

  // R3
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dm_rd_en |-> (slot_vld && !msg_all && !cmh_word[MSG_BIT]));
endmodule

// File: tb/tb_slot_src_sel.sv
module tb_slot_src_sel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, slot_vld, msg_all, ode_pin, dm_rd_en, out_vld, out_oe;
  logic [2:0] slot_stream, out_stream;
  logic [4:0] slot_chan, out_chan;
  logic [7:0] cmh_word, cml_word, dm_raddr, dm_rdata, out_data;
  logic [7:0] mem [256];

  assign dm_rdata = mem[dm_raddr];

  slot_src_sel dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model state
  int e_vld = 0, e_oe = 0, e_data = 0, e_str = 0, e_ch = 0;
  string tag_d = "R1", tag_o = "R1";
  bit e_rst = 1;

  always @(posedge clk) begin
    int src;
    bit m, d;
    src = int'(cmh_word[5:3]) * 32 + int'(cml_word[4:0]);
    if (!rst && slot_vld) begin
      chk("R3", dm_raddr, src);
      chk("R3", dm_rd_en, (!msg_all && !cmh_word[2]) ? 1 : 0);
    end else if (!rst) chk("R3", dm_rd_en, 0);
    e_rst = rst;
    if (rst) begin
      e_vld = 0; e_oe = 0; e_data = 0; e_str = 0; e_ch = 0;
      tag_d = "R1"; tag_o = "R1";
    end else if (!slot_vld) begin
      e_vld = 0; e_oe = 0; tag_d = "R9"; tag_o = "R9";
    end else begin
      m = msg_all || cmh_word[2];
      d = msg_all || cmh_word[0];
      e_vld = 1; e_str = slot_stream; e_ch = slot_chan;
      e_data = m ? cml_word : mem[src];
      e_oe = (ode_pin && d) ? 1 : 0;
      tag_d = msg_all ? "R6" : (cmh_word[2] ? "R4" : "R2");
      tag_o = !ode_pin ? "R7" : (msg_all ? "R6" : "R5");
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(e_rst ? "R1" : (e_vld ? "R8" : "R9"), out_vld, e_vld);
      chk(tag_o, out_oe, e_oe);
      chk(tag_d, out_data, e_data);
      chk(e_vld ? "R8" : tag_d, out_stream, e_str);
      chk(e_vld ? "R8" : tag_d, out_chan, e_ch);
    end
  end

  task automatic slot(input bit v, input int st, input int ch, input int h,
                      input int l, input bit ma, input bit od);
    @(negedge clk);
    slot_vld = v; slot_stream = 3'(st); slot_chan = 5'(ch);
    cmh_word = 8'(h); cml_word = 8'(l); msg_all = ma; ode_pin = od;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    rst = 1; slot_vld = 0; slot_stream = 0; slot_chan = 0;
    cmh_word = 8'hFF; cml_word = 8'hFF; msg_all = 0; ode_pin = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // switched, driven, several sources
    for (int i = 0; i < 16; i++)
      slot(1, i % 8, i, ((i % 8) << 3) | 1, (i * 3) & 31, 0, 1);
    // switched with cleared drive bit
    slot(1, 1, 2, 8'b0010_1000, 8'h1F, 0, 1);
    // per-entry message, with and without drive
    slot(1, 2, 3, 8'b0000_0101, 8'hA5, 0, 1);
    slot(1, 2, 4, 8'b0011_1100, 8'h5A, 0, 1);
    // global message overrides cleared bits
    slot(1, 3, 5, 8'b0010_0000, 8'hC3, 1, 1);
    slot(1, 3, 6, 8'h00, 8'h3C, 1, 1);
    // pin low silences everything
    slot(1, 4, 7, 8'h05, 8'h77, 1, 0);
    slot(1, 4, 8, 8'h01, 8'h12, 0, 0);
    // idle gaps hold data
    slot(0, 7, 31, 8'hFF, 8'hEE, 1, 1);
    slot(0, 6, 30, 8'h00, 8'h00, 0, 1);
    slot(1, 7, 31, 8'h39, 8'h1F, 0, 1);
    // mixed pseudo-random run
    for (int i = 0; i < 1500; i++) begin
      int r = (i * 1103515245 + 12345) >>> 4;
      slot((r & 7) != 0, r >> 3, r >> 6, r >> 11, r >> 19, (r & 96) == 96, (r & 768) != 0);
    end
    slot(0, 0, 0, 0, 0, 0, 1);
    // reset again mid-stream
    @(negedge clk); rst = 1; slot_vld = 1;
    @(negedge clk); @(negedge clk); rst = 0; slot_vld = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule